// File: doc/BRIEF.md
# Masked Data Breakpoint Comparator

This block sits beside the load/store stage of a processor pipeline and decides, access by access, whether a data breakpoint has been reached. It holds `NUM_BP` breakpoint slots. Each slot has a control word and a break address, and both are loaded through a single-cycle write port. The control word enables matching on loads and on stores separately. Its low six bits form an address mask that decides which of the lowest address bits take part in the compare.

Each access arrives with its byte address, a size code and a load/store flag. The access hits a slot when at least one byte it touches lies in the slot's masked address region. The result is registered. One cycle after the access, the block gives a hit strobe, the index of the winning slot and the debug cause value. No hit is raised while a debug exception is already in progress, or while the current interrupt level has reached the debug level.

Top module: `dbrk_match`

## Requirements
- R1: After reset, `hit_o`, `hit_idx_o` and `cause_o` are zero, and every control word and break address is zero, so no access hits until a slot is written.
- R2: When `wr_en_i` is high, `wr_data_i` is loaded into slot `wr_idx_i`. `wr_sel_i`=0 selects the control word and `wr_sel_i`=1 selects the break address. The new value is in effect from the next cycle, so an access in the same cycle as a write is judged against the old contents.
- R3: Control bit 30 enables hits on loads (`acc_store_i`=0) and control bit 31 enables hits on stores (`acc_store_i`=1). A control word of zero disables the slot.
- R4: Control bits 5:0 are a per-bit mask over address bits 5:0, where a 1 means the bit is compared. The mask applies bit by bit even when it has gaps, such as 0x35. Address bits 6 and above are always compared exactly.
- R5: `acc_size_i` encodes the access width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. An access hits when any byte address from `acc_addr_i` to `acc_addr_i`+width-1 matches the break address under the mask.
- R6: Break-address bits whose mask bit is 0 have no effect on the result, even when they are set.
- R7: The result for an access presented in cycle N appears on `hit_o` in cycle N+1, for one cycle per access.
- R8: When there is a hit, `cause_o` is 0x4 OR the slot index shifted left by 8. When there is no hit, `cause_o` and `hit_idx_o` are zero.
- R9: When several slots hit the same access, the lowest index is reported.
- R10: No hit is produced when `in_debug_i` is high, or when `int_level_i` is greater than or equal to the parameter `DBG_LEVEL`.
- R11: A cycle with `acc_valid_i` low produces no hit in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | IDX_W (1) | Slot selected for the write |
| wr_sel_i | input | 1 | 0: control word, 1: break address |
| wr_data_i | input | DATA_W (32) | Write data |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | ADDR_W (32) | Byte address of the access |
| acc_size_i | input | 2 | Width code: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes |
| acc_store_i | input | 1 | 1 for a store, 0 for a load |
| in_debug_i | input | 1 | A debug exception is being handled |
| int_level_i | input | LVL_W (4) | Current interrupt level |
| hit_o | output | 1 | Breakpoint hit, registered |
| hit_idx_o | output | IDX_W (1) | Index of the winning slot |
| cause_o | output | CAUSE_W (16) | Debug cause value for the hit |

## Verification
Two kinds of event can land in the same cycle. The first is a register write together with an access that the write would change. The bench writes a control word or break address in the same cycle as an access that hits only under the new value (or only under the old one), and expects the result to follow the old contents. It then repeats the access one cycle later and expects the result to follow the new contents. The second is both slots hitting a single access. Both slots are given overlapping regions and mixed enables, and the reported index must be the lowest slot enabled for that direction. A random phase mixes writes, accesses of all sizes and suppression, and compares every cycle against a behavioural model.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
  localparam int MASK_W        = 6;
  localparam int LD_EN_BIT     = 30;
  localparam int ST_EN_BIT     = 31;
  localparam int MAX_BYTES     = 4;
  localparam int NB_W          = $clog2(MAX_BYTES + 1);
  localparam int CAUSE_DATA    = 4;
  localparam int CAUSE_IDX_LSB = 8;
  localparam logic SEL_CTL     = 1'b0;
  localparam logic SEL_ADR     = 1'b1;

  function automatic logic [NB_W-1:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return NB_W'(1);
      2'd1:    return NB_W'(2);
      default: return NB_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/dbrk_regs.sv
module dbrk_regs import dbrk_pkg::*; #(
  parameter int NUM_BP = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] ctl_o [NUM_BP],
  output logic [ADDR_W-1:0] brk_o [NUM_BP]
);
  for (genvar b = 0; b < NUM_BP; b++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_o[b] <= '0;
        brk_o[b] <= '0;
      end else if (sel) begin
        if (wr_sel_i == SEL_CTL) ctl_o[b] <= wr_data_i;
        else                     brk_o[b] <= wr_data_i[ADDR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dbrk_cmp.sv
module dbrk_cmp import dbrk_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              valid_i,
  input  logic              store_i,
  input  logic              ld_en_i,
  input  logic              st_en_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [ADDR_W-1:0] brk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NB_W-1:0]   nbytes_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0]    mask;
  logic [MAX_BYTES-1:0] byte_hit;
  logic                 dir_en;

  // upper bits always compared
  assign mask = {{(ADDR_W-MASK_W){1'b1}}, mask_i};

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
    logic [ADDR_W-1:0] baddr;
    assign baddr       = addr_i + ADDR_W'(k);
    assign byte_hit[k] = (nbytes_i > NB_W'(k)) && (((baddr ^ brk_i) & mask) == '0);
  end

  assign dir_en = store_i ? st_en_i : ld_en_i;
  assign hit_o  = valid_i && dir_en && (|byte_hit);
endmodule

// File: rtl/dbrk_arb.sv
module dbrk_arb #(
  parameter int NUM_BP = 2,
  parameter int IDX_W  = 1
) (
  input  logic [NUM_BP-1:0] req_i,
  input  logic              block_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NUM_BP - 1; i >= 0; i--) begin
      if (req_i[i]) pick = IDX_W'(i);
    end
  end

  assign any_o = (|req_i) && !block_i;
  assign idx_o = any_o ? pick : '0;
endmodule

// File: rtl/dbrk_match.sv
module dbrk_match import dbrk_pkg::*; #(
  parameter int NUM_BP    = 2,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int LVL_W     = 4,
  parameter int DBG_LEVEL = 6,
  parameter int CAUSE_W   = 16,
  parameter int IDX_W     = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_sel_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               acc_valid_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [1:0]         acc_size_i,
  input  logic               acc_store_i,
  input  logic               in_debug_i,
  input  logic [LVL_W-1:0]   int_level_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [DATA_W-1:0]  ctl_q [NUM_BP];
  logic [ADDR_W-1:0]  brk_q [NUM_BP];
  logic [NUM_BP-1:0]  ld_en, st_en, bp_hit, unused_mid;
  logic [NB_W-1:0]    nbytes;
  logic               blocked, hit_d;
  logic [IDX_W-1:0]   idx_d;
  logic [CAUSE_W-1:0] cause_d;

  dbrk_regs #(
    .NUM_BP(NUM_BP), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .ctl_o    (ctl_q),
    .brk_o    (brk_q)
  );

  assign nbytes = size_to_bytes(acc_size_i);

  for (genvar b = 0; b < NUM_BP; b++) begin : g_cmp
    assign ld_en[b]      = ctl_q[b][LD_EN_BIT];
    assign st_en[b]      = ctl_q[b][ST_EN_BIT];
    assign unused_mid[b] = ^ctl_q[b][LD_EN_BIT-1:MASK_W];

    dbrk_cmp #(.ADDR_W(ADDR_W)) i_cmp (
      .valid_i (acc_valid_i),
      .store_i (acc_store_i),
      .ld_en_i (ld_en[b]),
      .st_en_i (st_en[b]),
      .mask_i  (ctl_q[b][MASK_W-1:0]),
      .brk_i   (brk_q[b]),
      .addr_i  (acc_addr_i),
      .nbytes_i(nbytes),
      .hit_o   (bp_hit[b])
    );
  end

  assign blocked = in_debug_i || (int_level_i >= LVL_W'(DBG_LEVEL));

  dbrk_arb #(.NUM_BP(NUM_BP), .IDX_W(IDX_W)) i_arb (
    .req_i  (bp_hit),
    .block_i(blocked),
    .any_o  (hit_d),
    .idx_o  (idx_d)
  );

  assign cause_d = hit_d ? (CAUSE_W'(CAUSE_DATA) | (CAUSE_W'(idx_d) << CAUSE_IDX_LSB)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
      cause_o   <= '0;
    end else begin
      hit_o     <= hit_d;
      hit_idx_o <= idx_d;
      cause_o   <= cause_d;
    end
  end
endmodule

// File: rtl/dbrk_match_chk.sv
module dbrk_match_chk #(
  parameter int NUM_BP    = 2,
  parameter int LVL_W     = 4,
  parameter int DBG_LEVEL = 6,
  parameter int CAUSE_W   = 16,
  parameter int IDX_W     = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               acc_valid_i,
  input logic               acc_store_i,
  input logic               in_debug_i,
  input logic [LVL_W-1:0]   int_level_i,
  input logic [NUM_BP-1:0]  ld_en_i,
  input logic [NUM_BP-1:0]  st_en_i,
  input logic               hit_o,
  input logic [IDX_W-1:0]   hit_idx_o,
  input logic [CAUSE_W-1:0] cause_o
);
  AST_STORE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_store_i && !(|st_en_i)) |=> !hit_o); // R3
  AST_LOAD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_store_i && !(|ld_en_i)) |=> !hit_o); // R3
  AST_DEBUG_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_debug_i |=> !hit_o); // R10
  AST_LEVEL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_level_i >= LVL_W'(DBG_LEVEL)) |=> !hit_o); // R10
  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !hit_o); // R11
  AST_CAUSE_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (cause_o == (CAUSE_W'(4) | (CAUSE_W'(hit_idx_o) << 8)))); // R8
  AST_QUIET_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (cause_o == '0 && hit_idx_o == '0)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (int'(hit_idx_o) < NUM_BP)); // R9
endmodule

bind dbrk_match dbrk_match_chk #(
  .NUM_BP(NUM_BP), .LVL_W(LVL_W), .DBG_LEVEL(DBG_LEVEL), .CAUSE_W(CAUSE_W), .IDX_W(IDX_W)
) i_dbrk_match_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_valid_i(acc_valid_i),
  .acc_store_i(acc_store_i),
  .in_debug_i (in_debug_i),
  .int_level_i(int_level_i),
  .ld_en_i    (ld_en),
  .st_en_i    (st_en),
  .hit_o      (hit_o),
  .hit_idx_o  (hit_idx_o),
  .cause_o    (cause_o)
);

// File: tb/test_dbrk_match.sv
`timescale 1ns/1ps
module test_dbrk_match;
  localparam int  NB    = 2;
  localparam int  DLVL  = 6;
  localparam time TCLK  = 4ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [0:0]  wr_idx_i = '0;
  logic        wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [1:0]  acc_size_i = '0;
  logic        acc_store_i = 1'b0;
  logic        in_debug_i = 1'b0;
  logic [3:0]  int_level_i = '0;
  logic        hit_o;
  logic [0:0]  hit_idx_o;
  logic [15:0] cause_o;

  always #(TCLK/2) clk = ~clk;

  dbrk_match i_dbrk_match (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i), .acc_size_i(acc_size_i),
    .acc_store_i(acc_store_i), .in_debug_i(in_debug_i), .int_level_i(int_level_i),
    .hit_o(hit_o), .hit_idx_o(hit_idx_o), .cause_o(cause_o)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_req = "R1", exp_req = "R1";
  bit    exp_hit = 0;
  int    exp_idx = 0;
  logic [31:0] m_ctl [NB];
  logic [31:0] m_brk [NB];

  function automatic void model(output bit h, output int idx);
    int nby;
    h = 0; idx = 0;
    if (!acc_valid_i || in_debug_i || int_level_i >= DLVL) return;
    nby = (acc_size_i == 0) ? 1 : (acc_size_i == 1) ? 2 : 4;
    for (int b = NB - 1; b >= 0; b--) begin
      bit en;
      logic [31:0] m;
      en = acc_store_i ? m_ctl[b][31] : m_ctl[b][30];
      m  = 32'hffff_ffc0 | {26'd0, m_ctl[b][5:0]};
      if (en) begin
        for (int k = 0; k < nby; k++) begin
          logic [31:0] ba;
          ba = acc_addr_i + k;
          if (((ba ^ m_brk[b]) & m) == 0) begin h = 1; idx = b; end
        end
      end
    end
  endfunction

  // one clock: check the previous result, drive, predict, update model
  task automatic step();
    bit h; int idx; logic [15:0] ec;
    n_chk++;
    ec = exp_hit ? (16'h4 | 16'(exp_idx << 8)) : 16'h0;
    if (hit_o !== exp_hit || int'(hit_idx_o) !== exp_idx || cause_o !== ec) begin
      n_fail++;
      $display("FAIL %s: hit=%0d idx=%0d cause=%h expected hit=%0d idx=%0d cause=%h",
               exp_req, hit_o, hit_idx_o, cause_o, exp_hit, exp_idx, ec);
    end
    model(h, idx);
    exp_hit = h; exp_idx = idx; exp_req = cur_req;
    if (wr_en_i) begin
      if (wr_sel_i) m_brk[wr_idx_i] = wr_data_i;
      else          m_ctl[wr_idx_i] = wr_data_i;
    end
    @(negedge clk);
  endtask

  task automatic clr();
    wr_en_i = 0; acc_valid_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin clr(); step(); end
  endtask

  task automatic wr(input int idx, input bit sel, input logic [31:0] d);
    clr();
    wr_en_i = 1; wr_idx_i = 1'(idx); wr_sel_i = sel; wr_data_i = d;
    step();
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input bit st);
    clr();
    acc_valid_i = 1; acc_addr_i = a; acc_size_i = sz; acc_store_i = st;
    step();
  endtask

  task automatic wr_acc(input int idx, input bit sel, input logic [31:0] d,
                        input logic [31:0] a, input logic [1:0] sz, input bit st);
    clr();
    wr_en_i = 1; wr_idx_i = 1'(idx); wr_sel_i = sel; wr_data_i = d;
    acc_valid_i = 1; acc_addr_i = a; acc_size_i = sz; acc_store_i = st;
    step();
  endtask

  task automatic setbp(input int idx, input logic [31:0] c, input logic [31:0] a);
    wr(idx, 1'b0, c);
    wr(idx, 1'b1, a);
  endtask

  initial begin
    #(TCLK * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R7: watchdog expired, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_ctl[b] = '0; m_brk[b] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state, and any access misses with cleared slots
    cur_req = "R1";
    idle(2);
    acc(32'h0, 2'd0, 0);
    acc(32'h0, 2'd2, 1);
    acc(32'hd000_007f, 2'd0, 0);

    // R3: separate enables for loads and stores, zero control disables
    cur_req = "R3";
    setbp(0, 32'h4000_003f, 32'hd000_007f);
    acc(32'hd000_007f, 2'd0, 0);
    acc(32'hd000_007f, 2'd0, 1);
    setbp(1, 32'h8000_003f, 32'hd000_007f);
    acc(32'hd000_007f, 2'd0, 1);
    acc(32'hd000_007f, 2'd0, 0);
    wr(0, 1'b0, 32'h0);
    acc(32'hd000_007f, 2'd0, 0);
    wr(1, 1'b0, 32'h0);
    acc(32'hd000_007f, 2'd0, 1);

    // R5: sizes and byte overlap
    cur_req = "R5";
    setbp(0, 32'h4000_003f, 32'hd000_007d);
    acc(32'hd000_007c, 2'd1, 0);
    acc(32'hd000_007c, 2'd2, 0);
    acc(32'hd000_007c, 2'd0, 0);
    acc(32'hd000_007a, 2'd1, 0);
    acc(32'hd000_007a, 2'd3, 0);
    setbp(1, 32'h8000_003e, 32'hd000_007e);
    acc(32'hd000_007f, 2'd0, 1);
    acc(32'hd000_007c, 2'd2, 1);
    acc(32'hd000_0080, 2'd0, 1);

    // R4: mask widths and the exactly compared upper bits
    cur_req = "R4";
    setbp(0, 32'h4000_0038, 32'hd000_0078);
    acc(32'hd000_007b, 2'd0, 0);
    acc(32'hd000_007c, 2'd2, 0);
    acc(32'hd000_0080, 2'd0, 0);
    setbp(0, 32'h4000_0030, 32'hd000_0070);
    acc(32'hd000_0075, 2'd0, 0);
    acc(32'hd000_0078, 2'd2, 0);
    acc(32'hd000_0060, 2'd2, 0);
    setbp(0, 32'h4000_0020, 32'hd000_0060);
    acc(32'hd000_006f, 2'd0, 0);
    acc(32'hd000_0074, 2'd2, 0);
    acc(32'hd000_1074, 2'd2, 0);
    acc(32'hd000_0040, 2'd0, 0);
    setbp(1, 32'h4000_0035, 32'hd000_0072);
    acc(32'hd000_0070, 2'd2, 0);
    acc(32'hd000_007a, 2'd0, 0);

    // R6: set break bits under a cleared mask are ignored
    cur_req = "R6";
    wr(1, 1'b0, 32'h0);
    setbp(0, 32'h4000_0030, 32'hd000_0071);
    acc(32'hd000_0070, 2'd1, 0);
    acc(32'hd000_007e, 2'd1, 0);
    setbp(0, 32'h4000_003c, 32'hd000_007f);
    acc(32'hd000_007c, 2'd0, 0);

    // R9: both slots hit, lowest index wins
    cur_req = "R9";
    setbp(0, 32'hc000_0030, 32'hd000_0070);
    setbp(1, 32'hc000_003f, 32'hd000_0074);
    acc(32'hd000_0074, 2'd2, 0);
    acc(32'hd000_0074, 2'd0, 1);
    wr(0, 1'b0, 32'h4000_0030);
    acc(32'hd000_0074, 2'd0, 1);
    acc(32'hd000_0074, 2'd0, 0);

    // R2: write and access in the same cycle use the old contents
    cur_req = "R2";
    wr_acc(0, 1'b0, 32'h0, 32'hd000_0070, 2'd0, 0);
    acc(32'hd000_0070, 2'd0, 0);
    wr_acc(1, 1'b1, 32'hd000_0070, 32'hd000_0070, 2'd0, 0);
    acc(32'hd000_0070, 2'd0, 0);
    wr_acc(0, 1'b0, 32'h8000_003f, 32'hd000_0070, 2'd0, 1);
    wr_acc(0, 1'b1, 32'hd000_0070, 32'hd000_0070, 2'd0, 1);
    acc(32'hd000_0070, 2'd0, 1);

    // R7: back-to-back accesses, one result each, then idle
    cur_req = "R7";
    acc(32'hd000_0070, 2'd0, 0);
    acc(32'hd000_0070, 2'd0, 1);
    acc(32'hd000_0010, 2'd0, 0);
    acc(32'hd000_0070, 2'd0, 0);
    idle(2);

    // R8: cause values for both indices
    cur_req = "R8";
    acc(32'hd000_0070, 2'd0, 1);
    acc(32'hd000_0070, 2'd0, 0);

    // R10: suppression by debug state and level
    cur_req = "R10";
    in_debug_i = 1;
    acc(32'hd000_0070, 2'd0, 0);
    in_debug_i = 0;
    int_level_i = 4'(DLVL);
    acc(32'hd000_0070, 2'd0, 0);
    int_level_i = 4'd15;
    acc(32'hd000_0070, 2'd0, 0);
    int_level_i = 4'(DLVL - 1);
    acc(32'hd000_0070, 2'd0, 0);
    int_level_i = 0;

    // R11: matching address but no valid
    cur_req = "R11";
    clr(); acc_addr_i = 32'hd000_0070; step();
    idle(1);

    // R5: random mix around a small window
    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      int r;
      clr();
      r = $urandom_range(0, 9);
      if (r < 2) begin
        wr_en_i = 1; wr_idx_i = 1'($urandom_range(0, 1)); wr_sel_i = 1'($urandom_range(0, 1));
        wr_data_i = wr_sel_i ? (32'hd000_0040 | 32'($urandom_range(0, 63)))
                             : ({2'($urandom_range(0, 3)), 24'd0, 6'($urandom_range(0, 63))});
      end
      acc_valid_i = ($urandom_range(0, 3) != 0);
      acc_addr_i  = 32'hd000_0040 | 32'($urandom_range(0, 63));
      if ($urandom_range(0, 15) == 0) acc_addr_i = acc_addr_i ^ 32'h0000_0100;
      acc_size_i  = 2'($urandom_range(0, 3));
      acc_store_i = 1'($urandom_range(0, 1));
      in_debug_i  = ($urandom_range(0, 15) == 0);
      int_level_i = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
      step();
    end
    in_debug_i = 0; int_level_i = 0;
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule